// File: doc/BRIEF.md
# CSMA Channel Access Controller

This block decides when a half-duplex powerline transmitter may drive the shared line. An analog front end supplies a signal level on every clock. The block compares that level against a programmable threshold. Only a presence that lasts without a break for a programmable number of milliseconds becomes a band-in-use flag. Short bursts are filtered out.

A transmit request starts an access attempt. The controller draws one of seven listening windows (85 to 115 ms in 5 ms steps) from a free-running pseudo-random sequence. It grants transmission only once the band has stayed clear for that whole window. If the band becomes busy partway through, the window is dropped and a fresh one is drawn. If no grant comes within a programmable overall timeout, the attempt is abandoned and a latched failure interrupt is raised.

All timing is counted in one-cycle pulses of a 1 ms tick, so the block does not depend on the system clock frequency. No data stream passes through it, so there is no valid/ready interface. Request, grant, clear and status are plain level or pulse pins. The requester needs no back-pressure: a request made while an attempt is running is dropped, not queued.

Top module: `csma_access_ctrl`

## Requirements
- R1: Carrier is present in a cycle when `sig_level` is greater than or equal to `cfg_level_thr`. A level below the threshold counts as absent.
- R2: `band_busy_o` rises at the clock edge that consumes the `cfg_persist_ms`-th tick of an unbroken carrier-present run. Any cycle without carrier clears the run count, and `band_busy_o` is low after that edge.
- R3: With a clear band, the number of ticks from request acceptance to grant is one of 85, 90, 95, 100, 105, 110 or 115. The value is picked by the low 3 bits of a 16-bit LFSR, and the value 7 is folded to index 0.
- R4: A grant only follows a window during which `band_busy_o` stayed low. If the band turns busy during listening, the window restarts with a new pick, and its ticks are counted from the first clear cycle.
- R5: `tx_grant` is high for exactly one cycle, after which the controller is idle.
- R6: `busy_o` is high from the cycle after a request is accepted through the last listening cycle. It is low in the grant cycle and after a timeout.
- R7: Ticks are counted from acceptance. At the edge of the tick that brings the count to `cfg_timeout_ms` without a grant, the attempt is abandoned and `fail_irq` sets.
- R8: `fail_irq` stays set until `fail_clr` is high at a clock edge. A failure and a clear in the same cycle leave it set.
- R9: `tx_req` is ignored while an attempt is running. It neither restarts the window nor the timeout count.
- R10: Synchronous reset `rst` returns the block to idle, with `tx_grant`, `busy_o`, `band_busy_o` and `fail_irq` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| sig_level | input | 8 | Per-cycle signal level from the front end |
| cfg_level_thr | input | 8 | Carrier detection threshold |
| cfg_persist_ms | input | 8 | Carrier run length, in ticks, needed to flag the band busy |
| cfg_timeout_ms | input | 12 | Overall access timeout in ticks (1100 to 3500 typical) |
| tx_req | input | 1 | Transmit request, accepted when idle |
| fail_clr | input | 1 | Clears the failure interrupt |
| tx_grant | output | 1 | One-cycle transmission grant |
| busy_o | output | 1 | Access attempt in progress |
| band_busy_o | output | 1 | Qualified band-in-use flag |
| fail_irq | output | 1 | Latched access-timeout interrupt |

## Verification
The failure set and the software clear of `fail_irq` can land on the same clock edge. To provoke this, the bench holds `fail_clr` high through a whole attempt on a permanently busy band, so that the timeout tick meets an active clear. It then checks that `fail_irq` reads high right after that tick edge and low one cycle later. A second overlap is a band-busy restart and window counting in the same listening cycle. The bench covers it by releasing the carrier mid-window and measuring the grant latency from the release.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_LISTEN = 2'd1,
    ACC_GRANT  = 2'd2
  } acc_state_t;

  // next value of a 16-bit Fibonacci LFSR, taps 16,14,13,11
  function automatic logic [15:0] lfsr16_next(input logic [15:0] cur);
    return {cur[14:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
  endfunction
endpackage

// File: rtl/csma_band_detect.sv
module csma_band_detect #(
  parameter int LVL_W = 8,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thr_i,
  input  logic [PER_W-1:0] persist_i,
  output logic             band_busy_o
);
  localparam logic [PER_W-1:0] RUN_MAX = {PER_W{1'b1}};

  logic             carrier;
  logic [PER_W-1:0] run_cnt;
  logic [PER_W-1:0] run_nxt;

  assign carrier = (level_i >= thr_i);

  always_comb begin
    run_nxt = run_cnt;
    if (ms_tick && run_cnt != RUN_MAX) run_nxt = run_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt     <= '0;
      band_busy_o <= 1'b0;
    end else if (!carrier) begin
      run_cnt     <= '0;
      band_busy_o <= 1'b0;
    end else begin
      run_cnt     <= run_nxt;
      band_busy_o <= (run_nxt >= persist_i);
    end
  end
endmodule

// File: rtl/csma_window_gen.sv
module csma_window_gen #(
  parameter int WIN_W     = 7,
  parameter int WIN_BASE  = 85,
  parameter int WIN_STEP  = 5,
  parameter int WIN_NUM   = 7,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [WIN_W-1:0] win_ms_o
);
  import csma_pkg::*;

  localparam int IDX_W = (WIN_NUM > 1) ? $clog2(WIN_NUM) : 1;
  localparam int TAB_N = 1 << IDX_W;

  logic [15:0]      lfsr;
  logic [IDX_W-1:0] raw_idx;
  logic [IDX_W-1:0] win_idx;
  logic [WIN_W-1:0] win_tab [TAB_N];

  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else     lfsr <= lfsr16_next(lfsr);
  end

  assign raw_idx = lfsr[IDX_W-1:0];

  // fold codes past the last window back into range
  always_comb begin
    if (int'(raw_idx) >= WIN_NUM) win_idx = IDX_W'(int'(raw_idx) - WIN_NUM);
    else                          win_idx = raw_idx;
  end

  for (genvar g = 0; g < TAB_N; g++) begin : g_tab
    if (g < WIN_NUM) begin : g_used
      assign win_tab[g] = WIN_W'(WIN_BASE + g * WIN_STEP);
    end else begin : g_spare
      assign win_tab[g] = WIN_W'(WIN_BASE);
    end
  end

  assign win_ms_o = win_tab[win_idx];
endmodule

// File: rtl/csma_access_fsm.sv
module csma_access_fsm #(
  parameter int WIN_W = 7,
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             tx_req,
  input  logic             band_busy,
  input  logic [WIN_W-1:0] win_ms,
  input  logic [TMO_W-1:0] timeout_ms,
  output logic             grant_o,
  output logic             busy_o,
  output logic             fail_evt_o
);
  import csma_pkg::*;

  acc_state_t       state;
  logic [WIN_W-1:0] win_len;
  logic [WIN_W-1:0] win_cnt;
  logic [TMO_W-1:0] tot_cnt;
  logic [TMO_W-1:0] tot_nxt;
  logic [WIN_W:0]   win_nxt;
  logic             win_done;
  logic             tmo_hit;

  always_comb begin
    tot_nxt = tot_cnt;
    if (ms_tick && tot_cnt != {TMO_W{1'b1}}) tot_nxt = tot_cnt + 1'b1;
    win_nxt  = {1'b0, win_cnt} + 1'b1;
    win_done = (state == ACC_LISTEN) && ms_tick && !band_busy &&
               (win_nxt >= {1'b0, win_len});
    // a completed window takes priority over the timeout
    tmo_hit  = (state == ACC_LISTEN) && ms_tick && !win_done &&
               (tot_nxt >= timeout_ms);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ACC_IDLE;
      win_len <= '0;
      win_cnt <= '0;
      tot_cnt <= '0;
    end else begin
      unique case (state)
        ACC_IDLE: begin
          if (tx_req) begin
            state   <= ACC_LISTEN;
            win_len <= win_ms;
            win_cnt <= '0;
            tot_cnt <= '0;
          end
        end
        ACC_LISTEN: begin
          tot_cnt <= tot_nxt;
          if (band_busy) begin
            win_len <= win_ms;
            win_cnt <= '0;
          end else if (ms_tick) begin
            win_cnt <= win_nxt[WIN_W-1:0];
          end
          if (win_done)     state <= ACC_GRANT;
          else if (tmo_hit) state <= ACC_IDLE;
        end
        ACC_GRANT: state <= ACC_IDLE;
        default:   state <= ACC_IDLE;
      endcase
    end
  end

  assign grant_o    = (state == ACC_GRANT);
  assign busy_o     = (state == ACC_LISTEN);
  assign fail_evt_o = tmo_hit;
endmodule

// File: rtl/csma_access_ctrl.sv
module csma_access_ctrl #(
  parameter int LVL_W    = 8,
  parameter int PER_W    = 8,
  parameter int TMO_W    = 12,
  parameter int WIN_W    = 7,
  parameter int WIN_BASE = 85,
  parameter int WIN_STEP = 5,
  parameter int WIN_NUM  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic [LVL_W-1:0] sig_level,
  input  logic [LVL_W-1:0] cfg_level_thr,
  input  logic [PER_W-1:0] cfg_persist_ms,
  input  logic [TMO_W-1:0] cfg_timeout_ms,
  input  logic             tx_req,
  input  logic             fail_clr,
  output logic             tx_grant,
  output logic             busy_o,
  output logic             band_busy_o,
  output logic             fail_irq
);
  logic [WIN_W-1:0] win_ms;
  logic             fail_evt;

  csma_band_detect #(.LVL_W(LVL_W), .PER_W(PER_W)) u_band (
    .clk         (clk),
    .rst         (rst),
    .ms_tick     (ms_tick),
    .level_i     (sig_level),
    .thr_i       (cfg_level_thr),
    .persist_i   (cfg_persist_ms),
    .band_busy_o (band_busy_o)
  );

  csma_window_gen #(
    .WIN_W(WIN_W), .WIN_BASE(WIN_BASE), .WIN_STEP(WIN_STEP), .WIN_NUM(WIN_NUM)
  ) u_win (
    .clk      (clk),
    .rst      (rst),
    .win_ms_o (win_ms)
  );

  csma_access_fsm #(.WIN_W(WIN_W), .TMO_W(TMO_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ms_tick    (ms_tick),
    .tx_req     (tx_req),
    .band_busy  (band_busy_o),
    .win_ms     (win_ms),
    .timeout_ms (cfg_timeout_ms),
    .grant_o    (tx_grant),
    .busy_o     (busy_o),
    .fail_evt_o (fail_evt)
  );

  // set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)           fail_irq <= 1'b0;
    else if (fail_evt) fail_irq <= 1'b1;
    else if (fail_clr) fail_irq <= 1'b0;
  end
endmodule

// File: rtl/csma_access_chk.sv
module csma_access_chk #(
  parameter int LVL_W = 8,
  parameter int PER_W = 8,
  parameter int TMO_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ms_tick,
  input logic [LVL_W-1:0] sig_level,
  input logic [LVL_W-1:0] cfg_level_thr,
  input logic [PER_W-1:0] cfg_persist_ms,
  input logic [TMO_W-1:0] cfg_timeout_ms,
  input logic             tx_req,
  input logic             fail_clr,
  input logic             tx_grant,
  input logic             busy_o,
  input logic             band_busy_o,
  input logic             fail_irq
);
  // R1
  band_needs_carrier_chk: assert property (@(posedge clk) disable iff (rst)
    band_busy_o |-> $past(sig_level >= cfg_level_thr));

  // R4
  grant_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> !$past(band_busy_o));

  // R5
  grant_single_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |=> !tx_grant);

  // R6
  grant_from_listen_chk: assert property (@(posedge clk) disable iff (rst)
    tx_grant |-> ($past(busy_o) && !busy_o));

  // R7
  fail_ends_attempt_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_irq) |-> (!busy_o && !tx_grant));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_irq && !fail_clr) |=> fail_irq);
endmodule

bind csma_access_ctrl csma_access_chk #(
  .LVL_W(LVL_W), .PER_W(PER_W), .TMO_W(TMO_W)
) u_chk (.*);

// File: tb/csma_access_ctrl_tb.sv
module csma_access_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic [7:0]  sig_level = 8'd0;
  logic [7:0]  cfg_level_thr = 8'd100;
  logic [7:0]  cfg_persist_ms = 8'd4;
  logic [11:0] cfg_timeout_ms = 12'd1100;
  logic        tx_req = 1'b0;
  logic        fail_clr = 1'b0;
  logic        tx_grant, busy_o, band_busy_o, fail_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  csma_access_ctrl u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .sig_level(sig_level),
    .cfg_level_thr(cfg_level_thr), .cfg_persist_ms(cfg_persist_ms),
    .cfg_timeout_ms(cfg_timeout_ms), .tx_req(tx_req), .fail_clr(fail_clr),
    .tx_grant(tx_grant), .busy_o(busy_o), .band_busy_o(band_busy_o),
    .fail_irq(fail_irq)
  );

  // persist, level, ticks, expected band flag (threshold 100)
  localparam logic [24:0] VEC [9] = '{
    {8'd4, 8'd200, 8'd1, 1'b0},
    {8'd4, 8'd200, 8'd3, 1'b0},
    {8'd4, 8'd200, 8'd4, 1'b1},
    {8'd4, 8'd200, 8'd7, 1'b1},
    {8'd2, 8'd200, 8'd1, 1'b0},
    {8'd2, 8'd200, 8'd2, 1'b1},
    {8'd4, 8'd99,  8'd6, 1'b0},
    {8'd4, 8'd100, 8'd4, 1'b1},
    {8'd1, 8'd255, 8'd1, 1'b1}
  };

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  task automatic req_pulse();
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) tx_req = 1'b0;
  endtask

  function automatic bit in_set(input int n);
    return (n >= 85) && (n <= 115) && ((n - 85) % 5 == 0);
  endfunction

  // ticks until grant, 0 if none within the limit
  task automatic ticks_to_grant(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      tick_once();
      if (tx_grant) begin n = i; break; end
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!tx_grant && !busy_o && !band_busy_o && !fail_irq, "R10 reset", 
        {tx_grant, busy_o, band_busy_o, fail_irq}, 0);

    // R1 / R2 table of carrier runs
    for (int v = 0; v < 9; v++) begin
      cfg_persist_ms = VEC[v][24:17];
      sig_level      = VEC[v][16:9];
      for (int t = 0; t < int'(VEC[v][8:1]); t++) tick_once();
      chk(band_busy_o == VEC[v][0], "R1/R2 band flag", band_busy_o, VEC[v][0]);
      sig_level = 8'd0;
      @(negedge clk);
      chk(!band_busy_o, "R2 flag clears", band_busy_o, 0);
    end
    cfg_persist_ms = 8'd4;

    // R2 broken run restarts count
    sig_level = 8'd200;
    repeat (3) tick_once();
    sig_level = 8'd0; @(negedge clk); sig_level = 8'd200;
    repeat (3) tick_once();
    chk(!band_busy_o, "R2 broken run", band_busy_o, 0);
    tick_once();
    chk(band_busy_o, "R2 run after break", band_busy_o, 1);
    sig_level = 8'd0; @(negedge clk);

    // R3 / R5 / R6 grants on a clear band
    for (int k = 0; k < 4; k++) begin
      repeat (k * 3 + 1) @(negedge clk);
      req_pulse();
      chk(busy_o, "R6 busy after accept", busy_o, 1);
      ticks_to_grant(130, n);
      chk(in_set(n), "R3 window length", n, 85);
      chk(!busy_o, "R6 busy low at grant", busy_o, 0);
      @(negedge clk);
      chk(!tx_grant, "R5 grant one cycle", tx_grant, 0);
    end

    // R4 band busy mid-window restarts
    req_pulse();
    ticks_to_grant(50, n);
    chk(n == 0, "R4 no early grant", n, 0);
    sig_level = 8'd200;
    repeat (4) tick_once();
    chk(band_busy_o && !tx_grant, "R4 band busy", band_busy_o, 1);
    sig_level = 8'd0;
    ticks_to_grant(130, n);
    chk(in_set(n), "R4 fresh window after clear", n, 85);

    // R7 timeout on a held band
    cfg_timeout_ms = 12'd1100;
    sig_level = 8'd200;
    req_pulse();
    repeat (1099) tick_once();
    chk(!fail_irq && busy_o, "R7 no early fail", fail_irq, 0);
    tick_once();
    chk(fail_irq && !busy_o, "R7 fail at timeout", fail_irq, 1);
    repeat (3) @(negedge clk);
    // R8 latched then cleared
    chk(fail_irq, "R8 irq latched", fail_irq, 1);
    fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;
    chk(!fail_irq, "R8 irq cleared", fail_irq, 0);

    // R9 request during attempt ignored
    cfg_timeout_ms = 12'd200;
    req_pulse();
    repeat (100) tick_once();
    req_pulse();
    repeat (99) tick_once();
    chk(!fail_irq, "R9 timeout not restarted early", fail_irq, 0);
    tick_once();
    chk(fail_irq, "R9 timeout from first request", fail_irq, 1);
    fail_clr = 1'b1; @(negedge clk); fail_clr = 1'b0;

    // R8 set and clear in the same cycle
    fail_clr = 1'b1;
    req_pulse();
    repeat (200) tick_once();
    chk(fail_irq, "R8 set wins over clear", fail_irq, 1);
    @(negedge clk);
    chk(!fail_irq, "R8 clear afterwards", fail_irq, 0);
    fail_clr = 1'b0;

    // R10 reset mid-attempt
    req_pulse();
    repeat (10) tick_once();
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk(!busy_o && !band_busy_o && !fail_irq, "R10 reset mid attempt",
        {busy_o, band_busy_o, fail_irq}, 0);
    sig_level = 8'd0;

    summary();
    $finish;
  end
endmodule